// File: doc/BRIEF.md
# Register-Programmed Clock and Reset Selector

This block chooses the clocks and resets for a memory subsystem. Software programs it through an APB slave that runs on a separate register clock. Two clock selectors each pick one of 32 global clocks. The first selection becomes the core clock, which serves the controller, the PHY and the 256-bit bus. The second selection becomes the clock of the 512-bit bus. The block also makes a half-rate PHY clock from the core clock.

Three reset selectors each pick one of 80 reset sources. Sources 0 to 31 are the global resets, which are active-high. Sources 32 to 79 are the configuration-startup resets, which are active-low. Every reset output is active-low. Each output goes low at once when its source is asserted. It is released in step with the clock of the domain it serves. The first reset output resets the register block itself, so software can reset its own selections from any chosen source.

Top module: `clkrst_select_unit`

## Requirements
- R1: Bits [4:0] of the register at offset 0x00 select which `glb_clk` bit is routed to `core_clk`.
- R2: Bits [12:8] of the register at offset 0x00 select which `glb_clk` bit is routed to `wide_clk`.
- R3: The register at offset 0x04 holds three reset select fields, in bits [6:0], [14:8] and [22:16]. They drive `csr_rst_n`, `ctl_rst_n` and `wide_rst_n` in that order. A value v below 32 selects `glb_rst[v]`, which is asserted when high. A value v from 32 to 79 selects `cfg_rst_n[v-32]`, which is asserted when low. Every output is low while its source is asserted.
- R4: A reset select value written above 79 is stored as 0 and reads back as 0.
- R5: An access to any address other than 0x00 or 0x04 returns `pslverr`=1 and `prdata`=0, and it changes no register.
- R6: A reset output goes low as soon as its selected source is asserted, without waiting for any clock edge.
- R7: After the source is deasserted, a reset output goes high on the second rising edge of its domain clock: `csr_clk`, `core_clk` or `wide_clk`.
- R8: `phy_clk` is low while `ctl_rst_n` is low. It first goes high on the first `core_clk` rising edge after `ctl_rst_n` has risen, and after that it toggles on every `core_clk` rising edge.
- R9: While `por_n` is low, and whenever `csr_rst_n` is low, all select fields are forced to 0.
- R10: `pready` is always 1. Register bits that hold no field read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_clk | input | 1 | Register and APB clock |
| por_n | input | 1 | Hard power-on reset, active-low |
| glb_clk | input | 32 | Global clock candidates |
| glb_rst | input | 32 | Global reset candidates, active-high |
| cfg_rst_n | input | 48 | Configuration-startup reset candidates, active-low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error for an unmapped address |
| core_clk | output | 1 | Selected clock for the controller, PHY and 256-bit bus |
| wide_clk | output | 1 | Selected clock for the 512-bit bus |
| phy_clk | output | 1 | Half-rate PHY clock derived from core_clk |
| csr_rst_n | output | 1 | Register block reset, released on csr_clk |
| ctl_rst_n | output | 1 | Controller/PHY/256-bit domain reset, released on core_clk |
| wide_rst_n | output | 1 | 512-bit domain reset, released on wide_clk |

## Verification
A reset source can assert in the same cycle as a domain clock edge that would otherwise complete a release. The asynchronous assertion must win, and the release count must start again from zero. Two further events can land on one CSR edge: an APB write that moves a select onto an already-asserted source, and the self-reset that this causes when the select is field 0. The bench provokes these by writing random select indices while it randomizes the global and startup reset vectors. It also pulses a source selected by field 0, then reads back that every field has returned to 0. Each output is judged against a bench function that decodes the index and polarity. The release timing is judged by counting domain clock edges at sample points that fall between edges.

// File: rtl/clkrst_pkg.sv
// Shared sizes and register offsets for the clock and reset selector.
package clkrst_pkg;
    localparam int N_GCLK  = 32;                    // global clock candidates
    localparam int N_GRST  = 32;                    // active-high global resets
    localparam int N_SRST  = 48;                    // active-low startup resets
    localparam int N_RSRC  = N_GRST + N_SRST;       // reset select range
    localparam int CSEL_W  = $clog2(N_GCLK);
    localparam int RSEL_W  = $clog2(N_RSRC);
    localparam int N_RCH   = 3;                     // reset channels
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam logic [ADDR_W-1:0] OFF_CLK = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RST = 8'h04;
endpackage

// File: rtl/clkrst_apb_regs.sv
// APB register file holding the clock and reset select fields.
// Assumes zero-wait APB transfers. rst_n is synchronous to clk and
// active-low. Reset select values outside the source range are stored as 0.
module clkrst_apb_regs
    import clkrst_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [DATA_W-1:0]             pwdata,
    output logic [DATA_W-1:0]             prdata,
    output logic                          pready,
    output logic                          pslverr,
    output logic [CSEL_W-1:0]             csel_core,
    output logic [CSEL_W-1:0]             csel_wide,
    output logic [N_RCH-1:0][RSEL_W-1:0]  rsel
);
    localparam int FLD = 8;                          // field pitch in bits

    logic mapped, wr_en;

    function automatic logic [RSEL_W-1:0] clamp_sel(input logic [RSEL_W-1:0] v);
        return (int'(v) > N_RSRC - 1) ? '0 : v;
    endfunction

    assign mapped  = (paddr == OFF_CLK) || (paddr == OFF_RST);
    assign wr_en   = psel && penable && pwrite && mapped;
    assign pready  = 1'b1;
    assign pslverr = psel && penable && !mapped;

    // Update select fields on a mapped write; reset forces index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_core <= '0;
            csel_wide <= '0;
            rsel      <= '0;
        end else if (wr_en) begin
            if (paddr == OFF_CLK) begin
                csel_core <= pwdata[0 +: CSEL_W];
                csel_wide <= pwdata[FLD +: CSEL_W];
            end else begin
                for (int k = 0; k < N_RCH; k++)
                    rsel[k] <= clamp_sel(pwdata[FLD*k +: RSEL_W]);
            end
        end
    end

    // Read mux: mapped registers only, with unused bits returned as zero.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (paddr == OFF_CLK) begin
                prdata[0 +: CSEL_W]   = csel_core;
                prdata[FLD +: CSEL_W] = csel_wide;
            end else if (paddr == OFF_RST) begin
                for (int k = 0; k < N_RCH; k++)
                    prdata[FLD*k +: RSEL_W] = rsel[k];
            end
        end
    end

    // R1: a clock select write lands in the field on the next edge
    p_csel_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == OFF_CLK)
        |=> csel_core == $past(pwdata[CSEL_W-1:0]));

    // R5: a write to an unmapped address leaves every field unchanged
    p_unmapped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && !mapped)
        |=> ($stable(rsel) && $stable(csel_core) && $stable(csel_wide)));

    // R4: a stored reset select never leaves the source range
    generate
        for (genvar g = 0; g < N_RCH; g++) begin : g_rng
            p_rsel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
                int'(rsel[g]) < N_RSRC);
        end
    endgenerate
endmodule

// File: rtl/clkrst_rst_chan.sv
// One reset channel: an 80-way source select with polarity merge, then a
// two-flop synchronizer that asserts asynchronously. Assumes sel is already
// in range; any other value falls back to source 0.
module clkrst_rst_chan
    import clkrst_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [N_GRST-1:0] glb_rst,
    input  logic [N_SRST-1:0] cfg_rst_n,
    input  logic [RSEL_W-1:0] sel,
    output logic              rst_n
);
    logic [N_RSRC-1:0] asrt;
    logic              src_on, arst_n, stage;

    assign asrt   = {~cfg_rst_n, glb_rst};
    assign src_on = (int'(sel) < N_RSRC) ? asrt[sel] : asrt[0];
    assign arst_n = por_n && !src_on;

    // Assert at once, release after two edges of the domain clock.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage <= 1'b0;
            rst_n <= 1'b0;
        end else begin
            stage <= 1'b1;
            rst_n <= stage;
        end
    end

    // R6: an asserted source is never seen with the output released
    p_assert_async_r6: assert property (@(posedge clk) disable iff (!por_n)
        src_on |-> !rst_n);

    // R7: a release is only seen once the source was quiet an edge earlier
    p_release_r7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> !$past(src_on));
endmodule

// File: rtl/clkrst_clk_div2.sv
// Half-rate clock from the core clock. The output is held low while the
// domain reset is low and toggles from the first edge after release.
module clkrst_clk_div2 (
    input  logic clk,
    input  logic rst_n,
    output logic q
);
    // Toggle on each edge; reset clears the phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= !q;
    end

    // R8: low while in reset
    p_phy_low_r8: assert property (@(posedge clk)
        !rst_n |-> !q);

    // R8: toggles on every edge once out of reset
    p_phy_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (q != $past(q)));
endmodule

// File: rtl/clkrst_select_unit.sv
// Top of the clock and reset selector. It holds the register file, the two
// clock selectors, three reset channels and the PHY half-rate clock. The
// clock selection is a plain mux, because glitch-free switching is not
// done here.
module clkrst_select_unit
    import clkrst_pkg::*;
(
    input  logic              csr_clk,
    input  logic              por_n,
    input  logic [N_GCLK-1:0] glb_clk,
    input  logic [N_GRST-1:0] glb_rst,
    input  logic [N_SRST-1:0] cfg_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              core_clk,
    output logic              wide_clk,
    output logic              phy_clk,
    output logic              csr_rst_n,
    output logic              ctl_rst_n,
    output logic              wide_rst_n
);
    logic [CSEL_W-1:0]            csel_core, csel_wide;
    logic [N_RCH-1:0][RSEL_W-1:0] rsel;
    logic [N_RCH-1:0]             dom_clk, dom_rst_n;
    logic                         reg_rst_n;

    assign reg_rst_n = por_n && csr_rst_n;

    clkrst_apb_regs u_regs (
        .clk       (csr_clk),
        .rst_n     (reg_rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr),
        .csel_core (csel_core),
        .csel_wide (csel_wide),
        .rsel      (rsel)
    );

    assign core_clk = glb_clk[csel_core];
    assign wide_clk = glb_clk[csel_wide];
    assign dom_clk  = {wide_clk, core_clk, csr_clk};

    generate
        for (genvar g = 0; g < N_RCH; g++) begin : g_rch
            clkrst_rst_chan u_chan (
                .clk       (dom_clk[g]),
                .por_n     (por_n),
                .glb_rst   (glb_rst),
                .cfg_rst_n (cfg_rst_n),
                .sel       (rsel[g]),
                .rst_n     (dom_rst_n[g])
            );
        end
    endgenerate

    assign csr_rst_n  = dom_rst_n[0];
    assign ctl_rst_n  = dom_rst_n[1];
    assign wide_rst_n = dom_rst_n[2];

    clkrst_clk_div2 u_div (
        .clk   (core_clk),
        .rst_n (ctl_rst_n),
        .q     (phy_clk)
    );

    // R9: the register block is held in reset while por_n is low
    p_por_holds_r9: assert property (@(posedge csr_clk)
        !por_n |=> !csr_rst_n);
endmodule

// File: tb/sim_clkrst_select_unit.sv
`timescale 1ns/1ps
module sim_clkrst_select_unit;
    logic        csr_clk = 1'b0;
    logic        por_n = 1'b0;
    logic [31:0] glb_clk = '0;
    logic [31:0] glb_rst = '0;
    logic [47:0] cfg_rst_n = '1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        core_clk, wide_clk, phy_clk, csr_rst_n, ctl_rst_n, wide_rst_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int unsigned seed_v;

    clkrst_select_unit u0 (.*);

    always #5 csr_clk = ~csr_clk;   // 100 MHz register clock

    // Each global clock has an integer half period from 3 to 7 ns.
    initial begin
        int t = 0;
        forever begin
            #1; t++;
            for (int i = 0; i < 32; i++)
                glb_clk[i] = ((t / (3 + i % 5)) % 2) != 0;
        end
    end

    function automatic bit exp_asrt(int idx, logic [31:0] g, logic [47:0] c);
        return (idx < 32) ? g[idx] : !c[idx-32];
    endfunction

    function automatic int clampv(int v);
        return (v > 79) ? 0 : v;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic apb_wr(logic [7:0] a, logic [31:0] d);
        @(negedge csr_clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge csr_clk);
        penable = 1;
        @(negedge csr_clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(logic [7:0] a, output logic [31:0] d, output logic err);
        @(negedge csr_clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge csr_clk);
        penable = 1;
        #1; d = prdata; err = pslverr;
        chk(pready == 1'b1, "R10 pready", pready, 1);
        @(negedge csr_clk);
        psel = 0; penable = 0;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        e;
        seed_v = $urandom(32'h5eed_c1c0);

        // Power-on reset state
        #23.3;
        chk(csr_rst_n == 0, "R9 csr_rst_n under por", csr_rst_n, 0);
        chk(ctl_rst_n == 0, "R9 ctl_rst_n under por", ctl_rst_n, 0);
        chk(phy_clk == 0, "R8 phy low in reset", phy_clk, 0);
        por_n = 1;
        #60;
        apb_rd(8'h00, d, e);
        chk(d == 0, "R9 clock selects after por", d, 0);
        apb_rd(8'h04, d, e);
        chk(d == 0, "R9 reset selects after por", d, 0);
        chk(csr_rst_n == 1, "R7 csr_rst_n released", csr_rst_n, 1);

        // Unused bits and field positions
        apb_wr(8'h00, 32'hFFFF_FFFF);
        apb_rd(8'h00, d, e);
        chk(d == 32'h0000_1F1F, "R10 unused bits zero", d, 32'h1F1F);
        chk(e == 0, "R5 no error on mapped read", e, 0);

        // Clamp: field0=100 -> 0, field1=79 kept, field2=80 -> 0
        apb_wr(8'h04, {8'h00, 8'd80, 8'd79, 8'd100});
        apb_rd(8'h04, d, e);
        chk(d == {8'h00, 8'd0, 8'd79, 8'd0}, "R4 clamp", d, {8'h00, 8'd0, 8'd79, 8'd0});

        // Unmapped access
        apb_rd(8'h08, d, e);
        chk(e == 1, "R5 pslverr", e, 1);
        chk(d == 0, "R5 prdata zero", d, 0);
        apb_wr(8'h0C, 32'h0000_0505);
        apb_rd(8'h00, d, e);
        chk(d == 32'h0000_1F1F, "R5 write ignored", d, 32'h1F1F);

        // Async assert, two-edge release and phy start on the core domain
        apb_wr(8'h00, 32'h0000_0302);            // core=2 (hp 5), wide=3
        apb_wr(8'h04, {8'h00, 8'd10, 8'd40, 8'd0});
        #60.3;
        cfg_rst_n[8] = 0;
        #0.3;
        chk(ctl_rst_n == 0, "R6 async assert", ctl_rst_n, 0);
        @(posedge core_clk); #0.3;
        cfg_rst_n[8] = 1;
        chk(ctl_rst_n == 0, "R7 held after deassert", ctl_rst_n, 0);
        @(posedge core_clk); #0.3;
        chk(ctl_rst_n == 0, "R7 low after first edge", ctl_rst_n, 0);
        chk(phy_clk == 0, "R8 phy low in reset", phy_clk, 0);
        @(posedge core_clk); #0.3;
        chk(ctl_rst_n == 1, "R7 high after second edge", ctl_rst_n, 1);
        chk(phy_clk == 0, "R8 phy still low at release edge", phy_clk, 0);
        @(posedge core_clk); #0.3;
        chk(phy_clk == 1, "R8 phy first rise", phy_clk, 1);
        @(posedge core_clk); #0.3;
        chk(phy_clk == 0, "R8 phy toggles", phy_clk, 0);

        // Self-reset through field 0 clears all fields
        apb_wr(8'h04, {8'h00, 8'd10, 8'd40, 8'd5});
        #20.3;
        glb_rst[5] = 1;
        #0.3;
        chk(csr_rst_n == 0, "R6 csr_rst_n async", csr_rst_n, 0);
        #30;
        glb_rst[5] = 0;
        #60;
        apb_rd(8'h04, d, e);
        chk(d == 0, "R9 self reset clears rst fields", d, 0);
        apb_rd(8'h00, d, e);
        chk(d == 0, "R9 self reset clears clk fields", d, 0);

        // Random selections and reset patterns (field 0 kept at 0)
        for (int it = 0; it < 60; it++) begin
            int c0, c1, r1, r2;
            logic [31:0] gv;
            logic [47:0] cv;
            c0 = $urandom_range(31); c1 = $urandom_range(31);
            r1 = $urandom_range(127); r2 = $urandom_range(127);
            if (it % 10 == 0) r1 = 79;
            if (it % 10 == 1) r2 = 32;
            if (it % 10 == 2) r1 = 31;
            gv = $urandom; gv[0] = 0;
            cv = {$urandom, $urandom};
            apb_wr(8'h00, {16'h0, 3'b0, c1[4:0], 3'b0, c0[4:0]});
            apb_wr(8'h04, {8'h00, 1'b0, r2[6:0], 1'b0, r1[6:0], 8'h00});
            #0.3;
            glb_rst = gv; cfg_rst_n = cv;
            #60;
            chk(ctl_rst_n == !exp_asrt(clampv(r1), gv, cv), "R3 ctl_rst_n",
                ctl_rst_n, !exp_asrt(clampv(r1), gv, cv));
            chk(wide_rst_n == !exp_asrt(clampv(r2), gv, cv), "R3 wide_rst_n",
                wide_rst_n, !exp_asrt(clampv(r2), gv, cv));
            for (int s = 0; s < 4; s++) begin
                #($urandom_range(9) + 1);
                chk(core_clk == glb_clk[c0], "R1 core_clk", core_clk, glb_clk[c0]);
                chk(wide_clk == glb_clk[c1], "R2 wide_clk", wide_clk, glb_clk[c1]);
            end
        end
        glb_rst = '0; cfg_rst_n = '1;
        #20;
        finish_run();
    end
endmodule